// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a processor's bus port and the memory or peripheral bus behind it. Two windows of the address map act as alias regions. Each 32-bit word in an alias region stands for a single bit of a word in a matching target region. A read of an alias word returns that one bit. A write of an alias word sets or clears that one bit and leaves the rest of the target word as it was. Any access outside both alias windows goes through to the target bus unchanged.

An alias write becomes a downstream read of the whole target word followed by a write of the modified word. A lock output toward the bus arbiter stays high from the read request until the write completes, so that no other master (a DMA engine, for example) can change the word in between. Each side uses a valid/ready request channel. Read data returns on a separate one-cycle valid strobe. The bridge handles one transaction at a time.

Top module: `bitband_bridge`

## Requirements
- R1: An access outside both alias windows is forwarded with the same address, direction and write data. Its read data is returned unchanged, and the lock output stays low.
- R2: Alias window 0x22000000..0x23FFFFFF maps onto target 0x20000000..0x200FFFFF, and alias window 0x42000000..0x43FFFFFF maps onto target 0x40000000..0x400FFFFF. For an alias offset `o` from the window base, the target word is `target_base + ((o >> 5) & ~3)` and the bit index is `(o >> 2) & 31`. Alias address bits [1:0] are ignored.
- R3: An alias write sets the addressed target bit when bit 0 of the write data is 1 and clears it when bit 0 is 0. All other bits of the target word are written back with their previous values.
- R4: An alias read returns the addressed target bit in bit 0 of the read data, and bits 31..1 are zero.
- R5: An alias write issues exactly one downstream read and then exactly one downstream write to the same target word. The lock is high at both handshakes and stays high while the write waits.
- R6: While a downstream request is valid and not ready, its valid, address, direction, write data and lock are held stable.
- R7: Read data reaches the upstream side in the cycle after the downstream read data arrives. The upstream ready is raised in the cycle after a transaction's final downstream handshake.
- R8: While reset is high, upstream ready, upstream read-valid, downstream valid and lock are all low. Ready rises one cycle after reset falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Bridge can accept a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_rvalid | output | 1 | Upstream read data valid (one-cycle pulse) |
| up_rdata | output | 32 | Upstream read data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 32 | Downstream word address |
| dn_wdata | output | 32 | Downstream write data |
| dn_lock | output | 1 | Arbiter lock during a read-modify-write |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
Timing is counted from the clock edge that accepts the upstream request. With a target that is always ready and answers one cycle after the handshake, read data (passthrough or alias) is due after the second following edge. A plain write frees the bridge after the first following edge, and an alias write frees it after the third. The bench counts falling edges after acceptance and requires those exact counts, so it samples each result in the cycle it becomes valid. A bus monitor counts downstream handshakes and records their addresses and lock values for each transaction. A stalled alias write checks that the lock is held while the target is not ready.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } bb_state_e;

  typedef enum logic [1:0] {
    OP_PASS   = 2'd0,
    OP_AREAD  = 2'd1,
    OP_AWRITE = 2'd2
  } bb_op_e;
endpackage

// File: rtl/bb_region_match.sv
// Decodes one alias window: hit flag, target word address and bit index.
module bb_region_match #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPAN_W = 20,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h2000_0000
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic                      hit,
  output logic [ADDR_W-1:0]         word_addr,
  output logic [$clog2(DATA_W)-1:0] bit_idx
);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int ALIGN_W = $clog2(DATA_W / 8);
  localparam int AS_W    = SPAN_W + BIT_W;   // alias window width

  logic [AS_W-1:0]   off;
  logic [ADDR_W-1:0] tgt_off;
  logic              unused_lsb;

  assign off        = addr[AS_W-1:0];
  assign hit        = (addr[ADDR_W-1:AS_W] == ALIAS_BASE[ADDR_W-1:AS_W]);
  assign tgt_off    = {{(ADDR_W-SPAN_W){1'b0}}, off[AS_W-1:BIT_W+ALIGN_W], {ALIGN_W{1'b0}}};
  assign word_addr  = TARGET_BASE + tgt_off;
  assign bit_idx    = off[ALIGN_W +: BIT_W];
  assign unused_lsb = ^off[ALIGN_W-1:0];
endmodule

// File: rtl/bb_bitop.sv
// Picks one bit of a word and builds the word with that bit replaced.
module bb_bitop #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         word,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic                      set_val,
  output logic [DATA_W-1:0]         merged,
  output logic                      picked
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = (bit_idx == i) ? set_val : word[i];
  end
  assign picked = word[bit_idx];

  always_comb begin
    assert_single_bit_R3: assert ($countones(merged ^ word) <= 1);
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPAN_W = 20,
  parameter int NREG   = 2,
  parameter logic [NREG-1:0][ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NREG-1:0][ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_rvalid,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_lock,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata
);
  localparam int BIT_W = $clog2(DATA_W);

  // ---------------- address decode, one matcher per window ----------------
  logic [NREG-1:0]             hit_vec;
  logic [NREG-1:0][ADDR_W-1:0] waddr_arr;
  logic [NREG-1:0][BIT_W-1:0]  bidx_arr;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    bb_region_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPAN_W(SPAN_W),
      .ALIAS_BASE(ALIAS_BASES[r]), .TARGET_BASE(TARGET_BASES[r])
    ) u_match (
      .addr(up_addr), .hit(hit_vec[r]),
      .word_addr(waddr_arr[r]), .bit_idx(bidx_arr[r])
    );
  end

  logic              a_hit;
  logic [ADDR_W-1:0] sel_waddr;
  logic [BIT_W-1:0]  sel_bidx;

  always_comb begin
    a_hit     = 1'b0;
    sel_waddr = '0;
    sel_bidx  = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hit_vec[r]) begin
        a_hit     = 1'b1;
        sel_waddr = waddr_arr[r];
        sel_bidx  = bidx_arr[r];
      end
    end
  end

  // ---------------- state ----------------
  bb_state_e        state;
  bb_op_e           op_q;
  logic [BIT_W-1:0] bit_q;
  logic             set_q;

  logic [DATA_W-1:0] merged;
  logic              picked;

  bb_bitop #(.DATA_W(DATA_W)) u_bitop (
    .word(dn_rdata), .bit_idx(bit_q), .set_val(set_q),
    .merged(merged), .picked(picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_PASS;
      bit_q     <= '0;
      set_q     <= 1'b0;
      up_ready  <= 1'b0;
      up_rvalid <= 1'b0;
      up_rdata  <= '0;
      dn_valid  <= 1'b0;
      dn_write  <= 1'b0;
      dn_addr   <= '0;
      dn_wdata  <= '0;
      dn_lock   <= 1'b0;
    end else begin
      up_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          up_ready <= 1'b1;
          if (up_valid && up_ready) begin
            up_ready <= 1'b0;
            dn_valid <= 1'b1;
            state    <= ST_REQ;
            if (a_hit) begin
              dn_addr  <= sel_waddr;
              dn_write <= 1'b0;          // alias always starts with a read
              dn_wdata <= '0;
              bit_q    <= sel_bidx;
              set_q    <= up_wdata[0];
              op_q     <= up_write ? OP_AWRITE : OP_AREAD;
              dn_lock  <= up_write;      // lock for the whole RMW
            end else begin
              dn_addr  <= up_addr;
              dn_write <= up_write;
              dn_wdata <= up_wdata;
              op_q     <= OP_PASS;
              dn_lock  <= 1'b0;
            end
          end
        end
        ST_REQ: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            if (dn_write) begin
              dn_lock  <= 1'b0;
              up_ready <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              state <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          if (dn_rvalid) begin
            if (op_q == OP_AWRITE) begin
              dn_wdata <= merged;
              dn_write <= 1'b1;
              dn_valid <= 1'b1;
              state    <= ST_REQ;
            end else begin
              up_rdata  <= (op_q == OP_AREAD) ? {{(DATA_W-1){1'b0}}, picked} : dn_rdata;
              up_rvalid <= 1'b1;
              up_ready  <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_hold_req_R6: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write)
                              && $stable(dn_wdata) && $stable(dn_lock));

  assert_locked_write_R5: assert property (@(posedge clk) disable iff (rst)
    dn_valid && dn_write && dn_lock |-> $past(dn_lock));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    up_ready |-> !dn_lock && !dn_valid);

  assert_alias_rd_zero_R4: assert property (@(posedge clk) disable iff (rst)
    up_rvalid && (op_q == OP_AREAD) |-> up_rdata[DATA_W-1:1] == '0);

  assert_rvalid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    up_rvalid |=> !up_rvalid);

  assert_disjoint_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic        up_ready, up_rvalid;
  logic [31:0] up_rdata;
  logic        dn_valid, dn_write, dn_lock;
  logic        dn_ready = 1'b1;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  bitband_bridge dut (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata),
    .up_rvalid(up_rvalid), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_lock(dn_lock),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  // target memory and bus monitor
  logic [31:0] mem [logic [31:0]];
  int          hs_cnt, lk_cnt, wr_cnt;
  logic [31:0] hs_first, hs_last;

  always @(posedge clk) begin
    dn_rvalid <= 1'b0;
    if (dn_valid && dn_ready) begin
      if (hs_cnt == 0) hs_first = dn_addr;
      hs_last = dn_addr;
      hs_cnt++;
      if (dn_lock) lk_cnt++;
      if (dn_write) begin
        wr_cnt++;
        mem[dn_addr] = dn_wdata;
      end else begin
        dn_rdata  <= mem.exists(dn_addr) ? mem[dn_addr] : 32'h0;
        dn_rvalid <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // expected target word for an alias address (R2 formula)
  function automatic logic [31:0] tgt_of(input logic [31:0] a);
    logic [31:0] base = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
    logic [31:0] o    = a & 32'h01FF_FFFF;
    return base + ((o >> 5) & ~32'h3);
  endfunction

  function automatic bit is_alias(input logic [31:0] a);
    return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
  endfunction

  task automatic txn(input bit wr, input logic [31:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input string req);
    int cyc = 0;
    int want;
    bit al = is_alias(a);
    @(negedge clk);
    hs_cnt = 0; lk_cnt = 0; wr_cnt = 0;
    up_valid = 1'b1; up_write = wr; up_addr = a; up_wdata = d;
    while (!up_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0;
    cyc = 1;
    while (!(wr ? up_ready : up_rvalid) && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    want = !wr ? 3 : (al ? 4 : 2);
    chk(cyc == want, "R7", "completion cycle", cyc, want);
    if (!wr) chk(up_rdata == exp, req, "read data", up_rdata, exp);
    if (!al) begin
      chk(hs_cnt == 1 && lk_cnt == 0 && hs_first == a, "R1", "forwarded access", hs_first, a);
    end else if (!wr) begin
      chk(hs_cnt == 1 && lk_cnt == 0 && wr_cnt == 0, "R4", "alias read bus use", hs_cnt, 1);
      chk(hs_first == tgt_of(a), "R2", "alias target addr", hs_first, tgt_of(a));
    end else begin
      chk(hs_cnt == 2 && lk_cnt == 2 && wr_cnt == 1, "R5", "locked RMW handshakes", lk_cnt, 2);
      chk(hs_first == tgt_of(a) && hs_last == tgt_of(a), "R2", "RMW target addr", hs_last, tgt_of(a));
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;   // write data or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h2000_0010, 32'hA5A5_0F0F, 4'd1},
    '{1'b0, 32'h2000_0010, 32'hA5A5_0F0F, 4'd1},
    '{1'b0, 32'h2200_0200, 32'h0000_0001, 4'd4},  // bit 0
    '{1'b0, 32'h2200_0210, 32'h0000_0000, 4'd4},  // bit 4
    '{1'b1, 32'h2200_0210, 32'h0000_0001, 4'd3},  // set bit 4
    '{1'b0, 32'h2000_0010, 32'hA5A5_0F1F, 4'd3},
    '{1'b1, 32'h2200_027C, 32'hFFFF_FFFE, 4'd3},  // clear bit 31
    '{1'b0, 32'h2000_0010, 32'h25A5_0F1F, 4'd3},
    '{1'b1, 32'h4000_0800, 32'h0000_0000, 4'd1},
    '{1'b1, 32'h4201_0034, 32'h0000_0001, 4'd2},  // bit 13
    '{1'b0, 32'h4000_0800, 32'h0000_2000, 4'd2},
    '{1'b0, 32'h4201_0034, 32'h0000_0001, 4'd2},
    '{1'b0, 32'h4201_0030, 32'h0000_0000, 4'd4},
    '{1'b1, 32'h4201_0047, 32'h0000_0003, 4'd2},  // byte 0x802 bit 1 -> bit 17, low addr bits ignored
    '{1'b0, 32'h4000_0800, 32'h0002_2000, 4'd2},
    '{1'b1, 32'h2000_0020, 32'hFFFF_FFFF, 4'd1},
    '{1'b0, 32'h2200_0424, 32'h0000_0001, 4'd4},  // all-ones word, upper bits zero
    '{1'b1, 32'h2000_0020, 32'h1234_5678, 4'd1},
    '{1'b1, 32'h3000_0000, 32'hDEAD_BEEF, 4'd1},
    '{1'b0, 32'h3000_0000, 32'hDEAD_BEEF, 4'd1},
    '{1'b1, 32'h2400_0000, 32'hCAFE_F00D, 4'd1},  // just above alias window
    '{1'b0, 32'h2400_0000, 32'hCAFE_F00D, 4'd1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(!up_ready && !up_rvalid && !dn_valid && !dn_lock, "R8", "outputs in reset",
        {up_ready, up_rvalid, dn_valid, dn_lock}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(up_ready == 1'b1, "R8", "ready after reset", up_ready, 1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      txn(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].data, req_name(VECS[i].req));
    end

    // R6/R5: stalled alias write holds request and lock (clear bit 0 of 0x20000010)
    @(negedge clk);
    dn_ready = 1'b0;
    up_valid = 1'b1; up_write = 1'b1; up_addr = 32'h2200_0200; up_wdata = 32'h0;
    while (!up_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    up_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dn_valid && dn_lock && !dn_write && dn_addr == 32'h2000_0010, "R6",
          "held locked read", dn_addr, 32'h2000_0010);
    end
    dn_ready = 1'b1;
    for (int k = 0; k < 20 && !up_ready; k++) begin
      @(negedge clk);
      if (dn_valid && dn_write)
        chk(dn_lock == 1'b1, "R5", "lock during write phase", dn_lock, 1);
    end
    txn(1'b0, 32'h2000_0010, 32'h0, 32'h25A5_0F1E, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule